// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic use an external asynchronous static RAM that has byte lanes. A requester offers one access at a time through a valid/ready handshake: an address, a write flag, write data and a per-byte lane mask. The controller turns each accepted access into a fixed sequence of clocked phases on the memory pins. It returns read data with a single-cycle valid pulse.

All memory controls are active low and come straight from flops. The data bus appears as a separate output word, a drive-enable and an input word, so the pad ring can build the tristate buffer. The phase lengths come from nanosecond timing parameters and the clock period. Each length is rounded up to whole cycles at elaboration. A write strobe is never lowered while the address can move. The bus is never driven while the memory may still be driving it.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request, chip enable, write enable, output enable and every byte strobe are high. The bus drive-enable is low, ready is high and the read valid is low.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready stays low from the next cycle until the access and any turnaround after it have finished.
- R3: A write stores only the byte lanes whose mask bit is 1. Mask bit 0 selects data bits 7:0 and mask bit 1 selects data bits 15:8. The strobe of a selected lane is low while write enable is low. The bus drive-enable is high for the whole time write enable is low.
- R4: Write enable is low only while chip enable is low. The address does not change in any cycle in which write enable is low.
- R5: The write-enable low pulse lasts WR_CYC cycles. WR_CYC is the larger of ceil(T_WP_NS/CLK_NS) and ceil(T_WC_NS/CLK_NS)-2, so that the write pulse and the full write cycle both meet their minimums.
- R6: During a read, output enable is low for ACC_CYC = ceil(T_AA_NS/CLK_NS) cycles. Read valid rises 1+ACC_CYC cycles after the accepting edge, holds the captured word and lasts exactly one cycle.
- R7: During a read, a lane whose mask bit is 0 keeps its strobe high, and that lane returns zero in the read data.
- R8: The bus drive-enable is never high while the memory is enabled for output (chip enable low, output enable low, write enable high).
- R9: After a read, the controller does not drive the bus until at least T_HZ_NS has passed since output enable rose. It holds chip enable high for max(1, ceil(T_HZ_NS/CLK_NS)) cycles before the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| req_be_i | input | DW/8 | Byte-lane mask, bit 0 = lowest byte |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | DW | Read data, unselected lanes zero |
| mem_addr_o | output | AW | Memory address |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_bs_n_o | output | DW/8 | Byte-lane strobes, active low, bit 0 = lowest byte |
| mem_dq_o | output | DW | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive-enable for mem_dq_o |
| mem_dq_i | input | DW | Data read from the memory bus |

## Verification
The bench builds the block with its default parameters: a 4 ns clock with the 70 ns grade timing. This gives an 18-cycle access, a 16-cycle write pulse (set by the write cycle, not the pulse width) and a 5-cycle turnaround. These are long enough that a window one cycle short is visible. The bench's memory model returns unknown data until the address access time has passed, keeps a float counter after output enable rises, and commits writes only on the rising edge of write enable. Shortened waits, missing turnaround and lane-mask mistakes therefore all show up at the ports.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACCESS,
    PH_HOLD,
    PH_TURN
  } phase_e;

  function automatic int unsigned cdiv(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW      = 5,
  parameter int unsigned ACC_CYC = 18,
  parameter int unsigned WR_CYC  = 16,
  parameter int unsigned TA_CYC  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          is_wr_i,
  input  logic          zero_i,
  output phase_e        phase_q_o,
  output phase_e        phase_d_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d    = phase_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (phase_q)
      PH_IDLE:   if (start_i) phase_d = PH_SETUP;
      PH_SETUP: begin
        phase_d    = PH_ACCESS;
        load_o     = 1'b1;
        load_val_o = is_wr_i ? CW'(WR_CYC - 1) : CW'(ACC_CYC - 1);
      end
      PH_ACCESS: if (zero_i) phase_d = PH_HOLD;
      PH_HOLD: begin
        if (is_wr_i) phase_d = PH_IDLE;
        else begin
          phase_d    = PH_TURN;
          load_o     = 1'b1;
          load_val_o = CW'(TA_CYC - 1);
        end
      end
      PH_TURN:   if (zero_i) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;

  // R9: a read always leaves through the turnaround phase
  a_r9_turn_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && !is_wr_i) |=> (phase_q == PH_TURN));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned CLK_NS  = 4,
  parameter int unsigned T_AA_NS = 70,
  parameter int unsigned T_WP_NS = 50,
  parameter int unsigned T_WC_NS = 70,
  parameter int unsigned T_HZ_NS = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  input  logic [DW/8-1:0] req_be_i,
  output logic            rsp_valid_o,
  output logic [DW-1:0]   rsp_rdata_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_ce_n_o,
  output logic            mem_we_n_o,
  output logic            mem_oe_n_o,
  output logic [DW/8-1:0] mem_bs_n_o,
  output logic [DW-1:0]   mem_dq_o,
  output logic            mem_dq_oe_o,
  input  logic [DW-1:0]   mem_dq_i
);

  localparam int unsigned NB      = DW / 8;
  localparam int unsigned ACC_CYC = umax(1, cdiv(T_AA_NS, CLK_NS));
  localparam int unsigned WC_MIN  = (cdiv(T_WC_NS, CLK_NS) > 2) ? cdiv(T_WC_NS, CLK_NS) - 2 : 1;
  localparam int unsigned WR_CYC  = umax(umax(1, cdiv(T_WP_NS, CLK_NS)), WC_MIN);
  localparam int unsigned TA_CYC  = umax(1, cdiv(T_HZ_NS, CLK_NS));
  localparam int unsigned MAX_CYC = umax(umax(ACC_CYC, WR_CYC), TA_CYC);
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  phase_e          phase_q, phase_d;
  logic            accept, zero, load;
  logic [CW-1:0]   load_val;

  logic            wr_q, wr_d;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [NB-1:0]   be_q, be_d;

  assign req_ready_o = (phase_q == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign wr_d        = accept ? req_we_i : wr_q;
  assign be_d        = accept ? req_be_i : be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      wr_q    <= req_we_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  sram_phase_fsm #(
    .CW(CW), .ACC_CYC(ACC_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .is_wr_i    (wr_q),
    .zero_i     (zero),
    .phase_q_o  (phase_q),
    .phase_d_o  (phase_d),
    .load_o     (load),
    .load_val_o (load_val)
  );

  sram_wait_cnt #(.CW(CW)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .zero_o (zero)
  );

  // pins come from flops, decoded from the next phase
  logic active_d;
  assign active_d = (phase_d == PH_SETUP) || (phase_d == PH_ACCESS) || (phase_d == PH_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ce_n_o  <= 1'b1;
      mem_we_n_o  <= 1'b1;
      mem_oe_n_o  <= 1'b1;
      mem_bs_n_o  <= '1;
      mem_dq_oe_o <= 1'b0;
    end else begin
      mem_ce_n_o  <= !active_d;
      mem_we_n_o  <= !((phase_d == PH_ACCESS) && wr_d);
      mem_oe_n_o  <= !((phase_d == PH_ACCESS) && !wr_d);
      mem_bs_n_o  <= active_d ? ~be_d : '1;
      mem_dq_oe_o <= active_d && wr_d;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;

  // read capture on the edge that closes the access wait
  logic          capture;
  logic [DW-1:0] rd_masked;
  assign capture = (phase_q == PH_ACCESS) && zero && !wr_q;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign rd_masked[8*g +: 8] = be_q[g] ? mem_dq_i[8*g +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= capture;
      if (capture) rsp_rdata_o <= rd_masked;
    end
  end

  a_r4_we_with_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> !mem_ce_n_o);

  a_r4_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> $stable(mem_addr_o));

  a_r8_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  a_r6_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int CLK_B  = 4;
  localparam int ACC_B  = (70 + CLK_B - 1) / CLK_B;
  localparam int WP_B   = (50 + CLK_B - 1) / CLK_B;
  localparam int WC_B   = (70 + CLK_B - 1) / CLK_B - 2;
  localparam int WR_B   = (WP_B > WC_B) ? WP_B : WC_B;
  localparam int HZ_B   = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic        req_ready, rsp_valid;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_bs_n;
  logic [15:0] mem_dq_i;

  always #2 clk = ~clk;

  sram_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_ce_n_o(mem_ce_n), .mem_we_n_o(mem_we_n),
    .mem_oe_n_o(mem_oe_n), .mem_bs_n_o(mem_bs_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] mem_m [int];
  logic [15:0] exp_m [int];
  logic [1:0]  cur_be = '0;

  function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  function automatic logic [15:0] lane_mask(logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // memory model: data valid only after the address access time
  int age = 0, fl_cnt = 100, wlen = 0, olen = 0;
  logic        p_we_n = 1, p_oe_n = 1, p_ce_n = 1;
  logic [15:0] p_addr = '0, p_dq = '0;
  logic [1:0]  p_bs = '1;

  always_comb begin
    logic [15:0] w;
    mem_dq_i = 'z;
    w = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 16'h0000;
    if (!mem_ce_n && mem_we_n && !mem_oe_n) begin
      if (!mem_bs_n[0]) mem_dq_i[7:0]  = (age > ACC_B) ? w[7:0]  : 8'hxx;
      if (!mem_bs_n[1]) mem_dq_i[15:8] = (age > ACC_B) ? w[15:8] : 8'hxx;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic drv;
      if (!mem_ce_n) age = (!p_ce_n && mem_addr == p_addr) ? age + 1 : 1;
      else age = 0;
      drv = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (drv) fl_cnt = 0; else if (fl_cnt < 1000) fl_cnt++;
      if (!mem_we_n && mem_ce_n) chk(0, "R4 we without ce", 0, 1);
      if (!mem_we_n && !p_we_n && mem_addr != p_addr) chk(0, "R4 addr moved", mem_addr, p_addr);
      if (!mem_we_n && !mem_dq_oe) chk(0, "R3 data not driven", 0, 1);
      if (mem_dq_oe && drv) chk(0, "R8 bus contention", 1, 0);
      if (mem_dq_oe && (fl_cnt - 1) * CLK_B < HZ_B) chk(0, "R9 drive before float", fl_cnt, HZ_B / CLK_B + 1);
      if (!mem_oe_n && mem_bs_n != ~cur_be) chk(0, "R7 read strobes", mem_bs_n, ~cur_be);
      if (!mem_we_n) wlen++;
      if (!mem_oe_n) olen++;
      if (!p_we_n && mem_we_n) begin
        logic [15:0] old;
        chk(wlen == WR_B, "R5 write pulse", wlen, WR_B);
        chk(p_bs == ~cur_be, "R3 write strobes", p_bs, ~cur_be);
        old = mem_m.exists(int'(p_addr)) ? mem_m[int'(p_addr)] : 16'h0000;
        if (!p_bs[0]) old[7:0]  = p_dq[7:0];
        if (!p_bs[1]) old[15:8] = p_dq[15:8];
        mem_m[int'(p_addr)] = old;
        wlen = 0;
      end
      if (!p_oe_n && mem_oe_n) begin
        chk(olen == ACC_B, "R6 output enable width", olen, ACC_B);
        olen = 0;
      end
      p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_ce_n = mem_ce_n;
      p_addr = mem_addr; p_dq = mem_dq_o; p_bs = mem_bs_n;
    end
  end

  task automatic do_op(bit we, logic [15:0] a, logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be; cur_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R2 ready low after accept", req_ready, 0);
    if (we) begin
      logic [15:0] old;
      old = exp_m.exists(int'(a)) ? exp_m[int'(a)] : 16'h0000;
      exp_m[int'(a)] = (old & ~lane_mask(be)) | (d & lane_mask(be));
    end else begin
      int lat = 0;
      logic [15:0] e;
      while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
      chk(lat == ACC_B + 1, "R6 read latency", lat, ACC_B + 1);
      e = (exp_m.exists(int'(a)) ? exp_m[int'(a)] : 16'h0000) & lane_mask(be);
      chk(rsp_rdata === e, "R3/R7 read data", rsp_rdata, e);
      @(negedge clk);
      chk(rsp_valid == 0, "R6 valid one cycle", rsp_valid, 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n} == 5'b11111, "R1 controls in reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n}, 5'b11111);
    chk(mem_dq_oe == 0 && rsp_valid == 0, "R1 drive/valid in reset", {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1 && mem_ce_n == 1 && mem_dq_oe == 0, "R1 idle after reset",
        {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);
    // directed corner cases
    do_op(1, 16'h0000, 16'hA55A, 2'b11);
    do_op(0, 16'h0000, 16'h0, 2'b11);
    do_op(1, 16'h0000, 16'h1234, 2'b01);   // R3 lower lane only
    do_op(0, 16'h0000, 16'h0, 2'b11);
    do_op(0, 16'h0000, 16'h0, 2'b10);      // R7 lower lane returns zero
    do_op(1, 16'hFFFF, 16'hBEEF, 2'b10);   // R9 write right after read
    do_op(0, 16'hFFFF, 16'h0, 2'b01);
    do_op(1, 16'h0001, 16'hCAFE, 2'b00);   // no lane written
    do_op(0, 16'h0001, 16'h0, 2'b11);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 250; i++) begin
      logic [15:0] a;
      case ($urandom % 4)
        0: a = 16'h0000;
        1: a = 16'hFFFF;
        default: a = 16'($urandom % 8);
      endcase
      do_op(1'($urandom % 2), a, 16'($urandom), 2'($urandom % 4));
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    foreach (exp_m[k]) begin
      logic [15:0] m;
      m = mem_m.exists(k) ? mem_m[k] : 16'h0000;
      chk(m == exp_m[k], "R3 memory contents", m, exp_m[k]);
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

endmodule